// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming frame is kept, using only its 48-bit destination address. The receive path gives it the destination address and the CRC-32 already computed over that address, both qualified by one strobe. One cycle later the block returns an accept decision and a 16-bit classification word, which the receive path merges into the frame's status.

Software programs the filter through a write-only port of 16-bit words. It holds four exact-match address entries: entry 0 is the station's own address and entries 1 to 3 are extra multicast slots. It also holds a 64-bit multicast hash table, stored as four 16-bit words, and two control bits. One control bit forces promiscuous acceptance. The other lets multicast frames be accepted through the hash table.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no result is presented, every table entry and both control bits are zero, and only the broadcast address is accepted.
- R2: A strobe on `dstValid` in one cycle gives `resValid` high in the next cycle, with the decision and status for that address. While `resValid` is low, `resAccept` is 0 and `resStatus` is 0.
- R3: The all-ones destination address is always accepted and sets status bit 5 (0x0020).
- R4: An address whose group bit `dstAddr[0]` is set, and which is not broadcast, sets status bit 4 (0x0010).
- R5: Exact entry n is written as three words at configuration addresses 0x08+4n (low word, `dstAddr[15:0]`), 0x09+4n (`dstAddr[31:16]`) and 0x0A+4n (`dstAddr[47:32]`). A destination equal to an entry sets status bit 2 (0x0004) and is accepted.
- R6: An entry whose three words are all zero never matches.
- R7: Status bits [1:0] give the lowest-numbered matching entry, and are 0 when no entry matches.
- R8: The hash index is `dstCrc[31:26]`. Index bits [5:4] select the table word written at address 0x01+w, and bits [3:0] select the bit in that word. A hit needs control bit 1 (hash enable, address 0x00) and a multicast, non-broadcast address. A hit sets status bit 3 (0x0008) and accepts the frame.
- R9: With control bit 0 (promiscuous, address 0x00) set, every frame is accepted, and the status flags keep their normal meaning.
- R10: A frame is accepted exactly when it is broadcast, matches an exact entry, hits the enabled hash, or promiscuous mode is on. Anything else, such as an unknown unicast address, is rejected.
- R11: A configuration write changes only lookups strobed in later cycles. A lookup strobed in the same cycle as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration word address |
| cfgWrData | input | 16 | Configuration write data |
| dstValid | input | 1 | Destination address valid strobe |
| dstAddr | input | 48 | Destination address, first byte on the wire in [7:0] |
| dstCrc | input | 32 | CRC-32 of the destination address |
| resValid | output | 1 | Result valid |
| resAccept | output | 1 | Frame accepted |
| resStatus | output | 16 | Classification flags and matched entry index |

## Verification
The bench builds the block with its default sizes: four exact entries and four 16-bit hash words. With these sizes the entry index uses both status bits, and any of the 64 hash positions can be reached by choosing the CRC directly. Directed cases cover the following:
- two entries holding the same address, to check index priority;
- a hash bit set while the enable is off;
- a unicast address whose CRC falls on a set hash bit;
- a write and a lookup landing in the same cycle.

Random writes, including writes to unmapped addresses, are then mixed with lookups drawn from the programmed entries.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int WORD_W       = 16;
  localparam int ENTRIES      = 4;
  localparam int ENT_WORDS    = 3;
  localparam int HASH_WORDS   = 4;
  localparam int ADDR_W       = WORD_W * ENT_WORDS;
  localparam int HASH_BITS    = HASH_WORDS * WORD_W;
  localparam int HASH_IDX_W   = $clog2(HASH_BITS);
  localparam int WSEL_W       = $clog2(HASH_WORDS);
  localparam int BSEL_W       = $clog2(WORD_W);
  localparam int IDX_W        = $clog2(ENTRIES);
  localparam int CRC_W        = 32;
  // status bit positions
  localparam int ST_BCAST     = 5;
  localparam int ST_MCAST     = 4;
  localparam int ST_HASH      = 3;
  localparam int ST_EXACT     = 2;

  typedef struct packed {
    logic                          ctlWe;
    logic [HASH_WORDS-1:0]         hashWe;
    logic [ENTRIES*ENT_WORDS-1:0]  entWe;
    logic [WORD_W-1:0]             data;
  } cfgStrobe_t;
endpackage

// File: rtl/rx_filt_ctrl.sv
module rx_filt_ctrl
  import rx_filt_pkg::*;
#(
  parameter int CFG_AW       = 6,
  parameter int HASH_BASE    = 1,
  parameter int ENTRY_BASE   = 8,
  parameter int ENTRY_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output cfgStrobe_t        stb
);
  always_comb begin
    stb.data  = cfgWrData;
    stb.ctlWe = cfgWe && (cfgAddr == '0);
    for (int w = 0; w < HASH_WORDS; w++)
      stb.hashWe[w] = cfgWe && (cfgAddr == CFG_AW'(HASH_BASE + w));
    for (int e = 0; e < ENTRIES; e++)
      for (int k = 0; k < ENT_WORDS; k++)
        stb.entWe[e*ENT_WORDS+k] =
          cfgWe && (cfgAddr == CFG_AW'(ENTRY_BASE + e*ENTRY_STRIDE + k));
  end

  // R11: a write touches at most one register
  p_single_target_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.ctlWe, stb.hashWe, stb.entWe}));
  // R11: no strobe without a write request
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !cfgWe |-> ({stb.ctlWe, stb.hashWe, stb.entWe} == '0));
endmodule

// File: rtl/rx_filt_datapath.sv
module rx_filt_datapath
  import rx_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        stb,
  input  logic              dstValid,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [CRC_W-1:0]  dstCrc,
  output logic              resValid,
  output logic              resAccept,
  output logic [WORD_W-1:0] resStatus
);
  logic                                    ctlPromisc, ctlHashEn;
  logic [HASH_WORDS-1:0][WORD_W-1:0]       hashTab;
  logic [ENTRIES-1:0][ENT_WORDS-1:0][WORD_W-1:0] entTab;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlPromisc <= 1'b0;
      ctlHashEn  <= 1'b0;
      hashTab    <= '0;
      entTab     <= '0;
    end else begin
      if (stb.ctlWe) begin
        ctlPromisc <= stb.data[0];
        ctlHashEn  <= stb.data[1];
      end
      for (int w = 0; w < HASH_WORDS; w++)
        if (stb.hashWe[w]) hashTab[w] <= stb.data;
      for (int e = 0; e < ENTRIES; e++)
        for (int k = 0; k < ENT_WORDS; k++)
          if (stb.entWe[e*ENT_WORDS+k]) entTab[e][k] <= stb.data;
    end
  end

  logic unusedCtlBits;
  assign unusedCtlBits = ^stb.data[WORD_W-1:2];
  logic unusedCrcLow;
  assign unusedCrcLow = ^dstCrc[CRC_W-HASH_IDX_W-1:0];

  // exact-match compare per entry
  logic [ENTRIES-1:0] entHit;
  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      logic [ADDR_W-1:0] entAddr;
      assign entAddr   = entTab[gi];
      assign entHit[gi] = (entAddr != '0) && (entAddr == dstAddr);
    end
  endgenerate

  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    hitIdx = '0;
    for (int e = ENTRIES-1; e >= 0; e--)
      if (entHit[e]) hitIdx = IDX_W'(e);
  end

  logic                  isBcast, isMcast, hashHit, exactHit, acceptNext;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic [WSEL_W-1:0]     hashWord;
  logic [BSEL_W-1:0]     hashBit;
  logic [WORD_W-1:0]     statusNext;

  assign isBcast   = &dstAddr;
  assign isMcast   = dstAddr[0] && !isBcast;
  assign hashIdx   = dstCrc[CRC_W-1 -: HASH_IDX_W];
  assign hashWord  = hashIdx[HASH_IDX_W-1 -: WSEL_W];
  assign hashBit   = hashIdx[BSEL_W-1:0];
  assign hashHit   = ctlHashEn && isMcast && hashTab[hashWord][hashBit];
  assign exactHit  = |entHit;
  assign acceptNext = isBcast || exactHit || hashHit || ctlPromisc;

  always_comb begin
    statusNext             = '0;
    statusNext[ST_BCAST]   = isBcast;
    statusNext[ST_MCAST]   = isMcast;
    statusNext[ST_HASH]    = hashHit;
    statusNext[ST_EXACT]   = exactHit;
    statusNext[IDX_W-1:0]  = hitIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      resAccept <= 1'b0;
      resStatus <= '0;
    end else begin
      resValid  <= dstValid;
      resAccept <= dstValid && acceptNext;
      resStatus <= dstValid ? statusNext : '0;
    end
  end

  p_follow_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    dstValid |=> resValid);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> (!resAccept && resStatus == '0));
  p_bcast_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (resValid && resStatus[ST_BCAST]) |-> resAccept);
  p_idx_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resStatus[ST_EXACT]) |-> (resStatus[IDX_W-1:0] == '0));
  p_hash_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (dstValid && !ctlHashEn) |=> !resStatus[ST_HASH]);
  p_promisc_all_r9: assert property (@(posedge clk) disable iff (rst)
    (dstValid && ctlPromisc) |=> resAccept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [15:0]       cfgWrData,
  input  logic              dstValid,
  input  logic [47:0]       dstAddr,
  input  logic [31:0]       dstCrc,
  output logic              resValid,
  output logic              resAccept,
  output logic [15:0]       resStatus
);
  cfgStrobe_t stb;

  rx_filt_ctrl #(.CFG_AW(CFG_AW)) i_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .stb(stb)
  );

  rx_filt_datapath i_dp (
    .clk(clk), .rst(rst), .stb(stb), .dstValid(dstValid),
    .dstAddr(dstAddr), .dstCrc(dstCrc), .resValid(resValid),
    .resAccept(resAccept), .resStatus(resStatus)
  );
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        dstValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [31:0] dstCrc = '0;
  logic        resValid, resAccept;
  logic [15:0] resStatus;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .dstValid(dstValid), .dstAddr(dstAddr),
    .dstCrc(dstCrc), .resValid(resValid), .resAccept(resAccept),
    .resStatus(resStatus)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] mEnt [4];
  logic [15:0] mHash [4];
  bit          mProm, mHen;
  logic        expValid, expAccept;
  logic [15:0] expStatus;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mEnt[i]) mEnt[i] = '0;
      foreach (mHash[i]) mHash[i] = '0;
      mProm = 0; mHen = 0;
      expValid = 0; expAccept = 0; expStatus = '0;
    end else begin
      bit bc, mc, hh, ex;
      int idx;
      bc = (dstAddr == {48{1'b1}});
      mc = dstAddr[0] && !bc;
      ex = 0; idx = 0;
      for (int e = 3; e >= 0; e--)
        if (mEnt[e] != 0 && mEnt[e] == dstAddr) begin ex = 1; idx = e; end
      hh = mHen && mc && mHash[dstCrc[31:30]][dstCrc[29:26]];
      expValid  = dstValid;
      expAccept = dstValid && (bc || ex || hh || mProm);
      expStatus = dstValid ? 16'((bc ? 32 : 0) + (mc ? 16 : 0) + (hh ? 8 : 0)
                                 + (ex ? 4 : 0) + idx) : 16'h0;
      if (cfgWe) begin
        int a;
        a = int'(cfgAddr);
        if (a == 0) begin mProm = cfgWrData[0]; mHen = cfgWrData[1]; end
        else if (a >= 1 && a <= 4) mHash[a-1] = cfgWrData;
        else if (a >= 8 && a < 24 && ((a-8) % 4) < 3)
          mEnt[(a-8)/4][16*((a-8)%4) +: 16] = cfgWrData;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 resValid vs model", 32'(resValid), 32'(expValid));
      chk("R10 resAccept vs model", 32'(resAccept), 32'(expAccept));
      chk("R4 resStatus vs model", 32'(resStatus), 32'(expStatus));
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    cfgWe = 1; cfgAddr = 6'(a); cfgWrData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic wrEnt(input int e, input logic [47:0] v);
    wr(8 + 4*e, v[15:0]);
    wr(9 + 4*e, v[31:16]);
    wr(10 + 4*e, v[47:32]);
  endtask

  task automatic look(input logic [47:0] a, input logic [31:0] c);
    dstValid = 1; dstAddr = a; dstCrc = c;
    @(negedge clk);
    dstValid = 0;
  endtask

  localparam logic [47:0] BCAST = {48{1'b1}};
  localparam logic [47:0] STA   = 48'h0A0B_0C0D_0E10;
  localparam logic [47:0] MC1   = 48'h0100_5E00_0001;
  localparam logic [47:0] MC2   = 48'h0000_0000_0033;
  localparam logic [47:0] UNI   = 48'h1234_5678_9A00;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset resValid", 32'(resValid), 0);
    chk("R1 reset resStatus", 32'(resStatus), 0);
    rst = 0;
    @(negedge clk);
    look(UNI, 0);
    chk("R1 unicast rejected after reset", 32'(resAccept), 0);
    look(BCAST, 0);
    chk("R3 broadcast accepted", 32'(resAccept), 1);
    chk("R3 broadcast flag", 32'(resStatus), 32'h20);
    look(48'h0, 0);
    chk("R6 zero entry no match", 32'(resAccept), 0);
    chk("R6 zero entry status", 32'(resStatus), 0);

    wrEnt(0, STA);
    look(STA, 0);
    chk("R5 station accepted", 32'(resAccept), 1);
    chk("R5 station status", 32'(resStatus), 32'h4);

    wrEnt(2, MC1);
    wrEnt(3, MC1);
    look(MC1, 0);
    chk("R7 lowest of two hits", 32'(resStatus), 32'h16);
    wrEnt(1, MC1);
    look(MC1, 0);
    chk("R7 entry1 wins", 32'(resStatus), 32'h15);
    chk("R4 multicast accepted by entry", 32'(resAccept), 1);

    wr(3, 16'h0020);
    look(MC2, 32'h9400_0000);
    chk("R8 hash disabled accept", 32'(resAccept), 0);
    chk("R8 hash disabled status", 32'(resStatus), 32'h10);
    wr(0, 16'h0002);
    look(MC2, 32'h9400_0000);
    chk("R8 hash hit accept", 32'(resAccept), 1);
    chk("R8 hash hit status", 32'(resStatus), 32'h18);
    look(MC2, 32'h9000_0000);
    chk("R8 neighbour bit miss", 32'(resAccept), 0);
    look(UNI, 32'h9400_0000);
    chk("R8 unicast ignores hash", 32'(resAccept), 0);
    chk("R10 unicast miss status", 32'(resStatus), 0);

    cfgWe = 1; cfgAddr = 0; cfgWrData = 16'h0000;
    dstValid = 1; dstAddr = MC2; dstCrc = 32'h9400_0000;
    @(negedge clk);
    cfgWe = 0; dstValid = 0;
    chk("R11 same-cycle uses old enable", 32'(resStatus), 32'h18);
    look(MC2, 32'h9400_0000);
    chk("R11 later lookup sees write", 32'(resAccept), 0);

    wr(0, 16'h0001);
    look(UNI, 0);
    chk("R9 promiscuous accept", 32'(resAccept), 1);
    chk("R9 promiscuous status", 32'(resStatus), 0);
    look(MC2, 32'h9400_0000);
    chk("R9 promiscuous mcast status", 32'(resStatus), 32'h10);
    wr(0, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      int pick;
      cfgWe = ($urandom_range(0, 7) == 0);
      cfgAddr = 6'($urandom_range(0, 25));
      cfgWrData = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      dstValid = ($urandom_range(0, 3) != 0);
      pick = $urandom_range(0, 5);
      case (pick)
        0: dstAddr = BCAST;
        1: dstAddr = 48'h0;
        2: dstAddr = STA;
        3: dstAddr = MC1;
        4: dstAddr = {47'($urandom_range(0, 3)), 1'b1};
        default: dstAddr = {16'($urandom), 32'($urandom)};
      endcase
      dstCrc = $urandom;
      @(negedge clk);
    end
    cfgWe = 0; dstValid = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL R2 watchdog: got=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule